// File: doc/BRIEF.md
# Entropy Source Run/Stop Sequencer

This block is the control state machine of a true random number generator. It decides when the free-running ring oscillators are powered and when sampled, conditioned words are allowed into the output FIFO. The oscillators, the conditioning function, the health-test arithmetic and the FIFO storage sit outside. This block only sees their verdicts and levels, and drives their enables.

After enable, the sequencer waits a programmable number of cycles. It then lets the two start-up tests count samples, and it holds FIFO writes off until every test that is not bypassed has reported a pass. Once running, a full FIFO starts a programmable switch-off timer. When the timer expires, the rings stop. They restart when the FIFO has drained to a threshold counted in 128-bit (four-word) blocks. A force-run control keeps the rings going regardless of the FIFO. A health failure parks the machine in an error state. The block also keeps a FIFO-full flag that a software write can clear, and an interrupt line gated by its own enable.

Top module: `trng_seq_ctrl`

## Requirements
- R1: The state code is 3 bits: 0 idle/reset, 1 start-up, 2 full with rings on, 3 full with rings off, 4 running, 5 error. After `rst`, the state is 0 and `osc_en_o`, `fifo_wr_en_o`, `full_flag_o`, `full_irq_o` and `pipe_clr_o` are all low.
- R2: While `enable_i` is low, the state is 0 one cycle later and the rings are off. From state 0 with `enable_i` high, the next state is 1.
- R3: `test_run_o` stays low for `init_wait_i` cycles after state 1 is entered, and rises in the `init_wait_i`-th cycle after entry.
- R4: A start-up pass counts only while `test_run_o` is high. State 4 follows two cycles after the last required pass. With both `skip_test0_i` and `skip_test1_i` high, state 4 follows one cycle after state 1 is entered. No FIFO write happens before state 4.
- R5: `fifo_wr_en_o` is high only in state 4. `osc_en_o` is high in states 1, 2 and 4, and low in states 0, 3 and 5. Both are registered and line up with `state_o`.
- R6: In state 4, a full FIFO with `force_run_i` low moves the machine to state 2. It stays there for `swoff_val_i`+1 cycles, then moves to state 3.
- R7: In state 2, a FIFO that is no longer full returns the machine to state 4. The next full starts the switch-off count again from `swoff_val_i`.
- R8: In state 3, the machine returns to state 4 in the cycle after `fifo_level_i` is at most 4×`restart_blocks_i` words.
- R9: With `force_run_i` high, state 4 is never left because of a full FIFO, and states 2 and 3 return to state 4.
- R10: A `health_fail_i` in state 1 or 4 moves the machine to state 5. State 5 holds until `soft_rst_i` is raised or `enable_i` is lowered.
- R11: `soft_rst_i` forces state 0 on the next cycle. `pipe_clr_o` is high in each cycle that follows a cycle with `soft_rst_i` high.
- R12: `full_flag_o` sets in the cycle after a rising edge of `fifo_full_i`. A `level_wr_i` pulse clears it one cycle later. If a set and a clear arrive in the same cycle, the set wins. `full_irq_o` is the flag ANDed with `full_ien_i` and is registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Generator enable |
| soft_rst_i | input | 1 | Software reset of sequencer and pipeline |
| force_run_i | input | 1 | Keep rings running on full FIFO |
| skip_test0_i | input | 1 | Bypass start-up test 0 |
| skip_test1_i | input | 1 | Bypass start-up test 1 |
| pass_test0_i | input | 1 | Start-up test 0 pass |
| pass_test1_i | input | 1 | Start-up test 1 pass |
| health_fail_i | input | 1 | Health or start-up test failure |
| fifo_level_i | input | FIFO_AW+1 | FIFO fill level in words |
| fifo_full_i | input | 1 | FIFO full |
| init_wait_i | input | CNT_W | Cycles to wait before start-up tests count |
| swoff_val_i | input | CNT_W | Extra cycles rings run after full |
| restart_blocks_i | input | FIFO_AW-1 | Restart level in four-word blocks |
| level_wr_i | input | 1 | Write strobe to the level register (clears flag) |
| full_ien_i | input | 1 | FIFO-full interrupt enable |
| osc_en_o | output | 1 | Ring oscillator enable |
| fifo_wr_en_o | output | 1 | FIFO write permission |
| test_run_o | output | 1 | Start-up tests may count samples |
| pipe_clr_o | output | 1 | Clear for health tests, conditioner and FIFO |
| state_o | output | 3 | State code |
| full_flag_o | output | 1 | FIFO-full interrupt flag |
| full_irq_o | output | 1 | FIFO-full interrupt request |

## Verification
The FIFO-full flag can be set by a rising full edge and cleared by a level-register write in the same cycle. The bench provokes this by raising `fifo_full_i` and pulsing `level_wr_i` before the same clock edge. It then judges that the flag reads one afterwards, because setting must win. The two state exits of the full-with-rings-on state, the switch-off expiry and the return on not-full, are also driven close together. A return just before expiry must restart the count at the full value on the next full.

// File: rtl/trng_seq_pkg.sv
package trng_seq_pkg;
  typedef enum logic [2:0] {
    ST_RESET   = 3'd0,
    ST_START   = 3'd1,
    ST_FULLON  = 3'd2,
    ST_FULLOFF = 3'd3,
    ST_RUN     = 3'd4,
    ST_ERROR   = 3'd5
  } seq_state_e;
endpackage

// File: rtl/trng_wait_gate.sv
// Start-up phase: initial wait counter and sticky pass latches per test.
module trng_wait_gate #(
  parameter int WAIT_W = 16,
  parameter int NTEST  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active_i,
  input  logic [WAIT_W-1:0] init_wait_i,
  input  logic [NTEST-1:0]  bypass_i,
  input  logic [NTEST-1:0]  pass_i,
  output logic              test_run_o,
  output logic              done_o
);
  logic [WAIT_W-1:0] wcnt;
  logic [NTEST-1:0]  ok_q;

  always_ff @(posedge clk) begin
    if (rst)                 wcnt <= '0;
    else if (!active_i)      wcnt <= init_wait_i;
    else if (wcnt != '0)     wcnt <= wcnt - 1'b1;
  end

  assign test_run_o = active_i && (wcnt == '0);

  for (genvar g = 0; g < NTEST; g++) begin : g_latch
    always_ff @(posedge clk) begin
      if (rst || !active_i)            ok_q[g] <= 1'b0;
      else if (test_run_o && pass_i[g]) ok_q[g] <= 1'b1;
    end
  end

  assign done_o = &(bypass_i | ok_q);
endmodule

// File: rtl/trng_swoff_timer.sv
// Counts down the extra run time after the FIFO fills; reloads when not armed.
module trng_swoff_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             armed_i,
  input  logic [CNT_W-1:0] load_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (!armed_i)   cnt <= load_i;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired_o = (cnt == '0);
endmodule

// File: rtl/trng_full_flag.sv
// FIFO-full event flag with write-to-clear and gated interrupt.
module trng_full_flag (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic full_i,
  input  logic wr_clr_i,
  input  logic ien_i,
  output logic flag_o,
  output logic irq_o
);
  logic full_q;
  logic flag_d;

  always_comb begin
    flag_d = flag_o;
    if (clr_i)                flag_d = 1'b0;
    else if (full_i && !full_q) flag_d = 1'b1;
    else if (wr_clr_i)        flag_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      flag_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      full_q <= full_i;
      flag_o <= flag_d;
      irq_o  <= flag_d & ien_i;
    end
  end
endmodule

// File: rtl/trng_seq_ctrl.sv
module trng_seq_ctrl
  import trng_seq_pkg::*;
#(
  parameter int FIFO_AW = 6,
  parameter int CNT_W   = 16,
  localparam int LVL_W  = FIFO_AW + 1,
  localparam int BLK_W  = LVL_W - 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable_i,
  input  logic             soft_rst_i,
  input  logic             force_run_i,
  input  logic             skip_test0_i,
  input  logic             skip_test1_i,
  input  logic             pass_test0_i,
  input  logic             pass_test1_i,
  input  logic             health_fail_i,
  input  logic [LVL_W-1:0] fifo_level_i,
  input  logic             fifo_full_i,
  input  logic [CNT_W-1:0] init_wait_i,
  input  logic [CNT_W-1:0] swoff_val_i,
  input  logic [BLK_W-1:0] restart_blocks_i,
  input  logic             level_wr_i,
  input  logic             full_ien_i,
  output logic             osc_en_o,
  output logic             fifo_wr_en_o,
  output logic             test_run_o,
  output logic             pipe_clr_o,
  output logic [2:0]       state_o,
  output logic             full_flag_o,
  output logic             full_irq_o
);
  seq_state_e st, nxt;
  logic start_done;
  logic swoff_done;
  logic [LVL_W-1:0] thr_words;

  assign thr_words = {restart_blocks_i, 2'b00};

  trng_wait_gate #(.WAIT_W(CNT_W), .NTEST(2)) u_gate (
    .clk        (clk),
    .rst        (rst),
    .active_i   (st == ST_START),
    .init_wait_i(init_wait_i),
    .bypass_i   ({skip_test1_i, skip_test0_i}),
    .pass_i     ({pass_test1_i, pass_test0_i}),
    .test_run_o (test_run_o),
    .done_o     (start_done)
  );

  trng_swoff_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .armed_i  (st == ST_FULLON),
    .load_i   (swoff_val_i),
    .expired_o(swoff_done)
  );

  trng_full_flag u_flag (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (soft_rst_i),
    .full_i  (fifo_full_i),
    .wr_clr_i(level_wr_i),
    .ien_i   (full_ien_i),
    .flag_o  (full_flag_o),
    .irq_o   (full_irq_o)
  );

  always_comb begin
    nxt = st;
    if (!enable_i || soft_rst_i) begin
      nxt = ST_RESET;
    end else begin
      case (st)
        ST_RESET:   nxt = ST_START;
        ST_START:   if (health_fail_i) nxt = ST_ERROR;
                    else if (start_done) nxt = ST_RUN;
        ST_RUN:     if (health_fail_i) nxt = ST_ERROR;
                    else if (fifo_full_i && !force_run_i) nxt = ST_FULLON;
        ST_FULLON:  if (!fifo_full_i || force_run_i) nxt = ST_RUN;
                    else if (swoff_done) nxt = ST_FULLOFF;
        ST_FULLOFF: if (force_run_i || (fifo_level_i <= thr_words)) nxt = ST_RUN;
        ST_ERROR:   nxt = ST_ERROR;
        default:    nxt = ST_RESET;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_RESET;
      osc_en_o     <= 1'b0;
      fifo_wr_en_o <= 1'b0;
      pipe_clr_o   <= 1'b0;
    end else begin
      st           <= nxt;
      osc_en_o     <= (nxt == ST_START) || (nxt == ST_RUN) || (nxt == ST_FULLON);
      fifo_wr_en_o <= (nxt == ST_RUN);
      pipe_clr_o   <= soft_rst_i;
    end
  end

  assign state_o = st;
endmodule

// File: rtl/trng_seq_ctrl_chk.sv
module trng_seq_ctrl_chk #(
  parameter int FIFO_AW = 6,
  parameter int CNT_W   = 16
) (
  input logic       clk,
  input logic       rst,
  input logic       enable_i,
  input logic       soft_rst_i,
  input logic       force_run_i,
  input logic       health_fail_i,
  input logic       fifo_full_i,
  input logic       level_wr_i,
  input logic       osc_en_o,
  input logic       fifo_wr_en_o,
  input logic       pipe_clr_o,
  input logic [2:0] state_o,
  input logic       full_flag_o
);
  // R1: only defined codes appear
  p_state_legal_r1: assert property (@(posedge clk) disable iff (rst)
    state_o <= 3'd5);

  // R2
  p_off_when_disabled_r2: assert property (@(posedge clk) disable iff (rst)
    !enable_i |=> (state_o == 3'd0) && !osc_en_o);

  // R5
  p_write_only_running_r5: assert property (@(posedge clk) disable iff (rst)
    fifo_wr_en_o |-> (state_o == 3'd4));

  // R5
  p_rings_off_states_r5: assert property (@(posedge clk) disable iff (rst)
    ((state_o == 3'd0) || (state_o == 3'd3) || (state_o == 3'd5)) |-> !osc_en_o);

  // R9
  p_force_keeps_running_r9: assert property (@(posedge clk) disable iff (rst)
    ((state_o == 3'd4) && force_run_i && enable_i && !soft_rst_i && !health_fail_i)
    |=> (state_o == 3'd4));

  // R10
  p_error_holds_r10: assert property (@(posedge clk) disable iff (rst)
    ((state_o == 3'd5) && enable_i && !soft_rst_i) |=> (state_o == 3'd5));

  // R11
  p_soft_clear_r11: assert property (@(posedge clk) disable iff (rst)
    soft_rst_i |=> pipe_clr_o && (state_o == 3'd0));

  // R12
  p_flag_cleared_r12: assert property (@(posedge clk) disable iff (rst)
    (level_wr_i && !fifo_full_i) |=> !full_flag_o);
endmodule

bind trng_seq_ctrl trng_seq_ctrl_chk #(.FIFO_AW(FIFO_AW), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/trng_seq_ctrl_tb_top.sv
module trng_seq_ctrl_tb_top;
  localparam int FIFO_AW = 6;
  localparam int CNT_W   = 16;
  localparam int LVL_W   = FIFO_AW + 1;
  localparam int BLK_W   = LVL_W - 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable_i = 0, soft_rst_i = 0, force_run_i = 0;
  logic skip_test0_i = 0, skip_test1_i = 0, pass_test0_i = 0, pass_test1_i = 0;
  logic health_fail_i = 0, fifo_full_i = 0, level_wr_i = 0, full_ien_i = 0;
  logic [LVL_W-1:0] fifo_level_i = '0;
  logic [CNT_W-1:0] init_wait_i = '0, swoff_val_i = '0;
  logic [BLK_W-1:0] restart_blocks_i = '0;
  logic osc_en_o, fifo_wr_en_o, test_run_o, pipe_clr_o, full_flag_o, full_irq_o;
  logic [2:0] state_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  trng_seq_ctrl #(.FIFO_AW(FIFO_AW), .CNT_W(CNT_W)) dut_i (.*);

  task automatic tick(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FIFO seq FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_st(input string req, input int exp);
    chk(state_o == exp, req, state_o, exp);
  endtask

  task automatic go_idle();
    enable_i = 0; soft_rst_i = 0; force_run_i = 0; health_fail_i = 0;
    skip_test0_i = 0; skip_test1_i = 0; pass_test0_i = 0; pass_test1_i = 0;
    fifo_full_i = 0; level_wr_i = 0; init_wait_i = 0;
    tick(2);
  endtask

  task automatic to_running();
    go_idle();
    skip_test0_i = 1; skip_test1_i = 1; enable_i = 1;
    tick(2);
  endtask

  task automatic t_reset();
    rst = 1; tick(3); rst = 0;
    chk_st("R1 reset state", 0);
    chk(!osc_en_o && !fifo_wr_en_o && !full_flag_o && !full_irq_o && !pipe_clr_o,
        "R1 reset outputs", {osc_en_o, fifo_wr_en_o, full_flag_o, full_irq_o, pipe_clr_o}, 0);
  endtask

  task automatic t_bypass();
    go_idle();
    skip_test0_i = 1; skip_test1_i = 1; enable_i = 1;
    tick();
    chk_st("R2 enable enters start-up", 1);
    chk(osc_en_o && !fifo_wr_en_o, "R5 start-up rings on no write", {osc_en_o, fifo_wr_en_o}, 2);
    tick();
    chk_st("R4 both bypassed runs at once", 4);
    chk(fifo_wr_en_o && osc_en_o, "R5 running outputs", {osc_en_o, fifo_wr_en_o}, 3);
    enable_i = 0;
    tick();
    chk_st("R2 disable returns to idle", 0);
    chk(!osc_en_o, "R2 rings off when disabled", osc_en_o, 0);
  endtask

  task automatic t_init_wait();
    go_idle();
    init_wait_i = 5; pass_test0_i = 1; pass_test1_i = 1; enable_i = 1;
    tick();
    chk_st("R3 entry", 1);
    chk(!test_run_o, "R3 run low at entry", test_run_o, 0);
    tick(4);
    chk(!test_run_o, "R3 run low before wait ends", test_run_o, 0);
    tick();
    chk(test_run_o, "R3 run high after wait", test_run_o, 1);
    tick();
    chk_st("R4 still in start-up after pass", 1);
    chk(!fifo_wr_en_o, "R4 no write before tests done", fifo_wr_en_o, 0);
    tick();
    chk_st("R4 running after passes", 4);
  endtask

  task automatic t_one_test();
    go_idle();
    skip_test0_i = 1; enable_i = 1;
    tick(6);
    chk_st("R4 waits for unbypassed test", 1);
    chk(!fifo_wr_en_o, "R4 writes held off", fifo_wr_en_o, 0);
    pass_test1_i = 1;
    tick();
    pass_test1_i = 0;
    chk_st("R4 one cycle after pass", 1);
    tick();
    chk_st("R4 two cycles after pass", 4);
  endtask

  task automatic t_swoff_restart();
    to_running();
    swoff_val_i = 3; fifo_full_i = 1;
    tick();
    chk_st("R6 full enters rings-on", 2);
    tick(3);
    chk_st("R6 still rings-on at count end", 2);
    chk(osc_en_o, "R6 rings still on", osc_en_o, 1);
    tick();
    chk_st("R6 rings-off after count", 3);
    chk(!osc_en_o, "R6 rings stopped", osc_en_o, 0);
    fifo_full_i = 0; restart_blocks_i = 2; fifo_level_i = 9;
    tick();
    chk_st("R8 above threshold stays off", 3);
    fifo_level_i = 8;
    tick();
    chk_st("R8 restart at threshold", 4);
    chk(osc_en_o, "R8 rings back on", osc_en_o, 1);
  endtask

  task automatic t_reload();
    to_running();
    swoff_val_i = 3; fifo_full_i = 1;
    tick(3);
    chk_st("R7 counting", 2);
    fifo_full_i = 0;
    tick();
    chk_st("R7 not-full returns to running", 4);
    fifo_full_i = 1;
    tick(4);
    chk_st("R7 count restarted full length", 2);
    tick();
    chk_st("R7 expires after reload", 3);
  endtask

  task automatic t_force();
    to_running();
    swoff_val_i = 0; force_run_i = 1; fifo_full_i = 1;
    tick(6);
    chk_st("R9 force keeps running", 4);
    chk(osc_en_o, "R9 rings on", osc_en_o, 1);
    force_run_i = 0;
    tick(2);
    chk_st("R9 without force reaches off", 3);
    force_run_i = 1;
    tick();
    chk_st("R9 force leaves off state", 4);
  endtask

  task automatic t_error();
    to_running();
    health_fail_i = 1;
    tick();
    chk_st("R10 failure enters error", 5);
    chk(!osc_en_o && !fifo_wr_en_o, "R10 error outputs off", {osc_en_o, fifo_wr_en_o}, 0);
    health_fail_i = 0;
    tick(3);
    chk_st("R10 error holds", 5);
    soft_rst_i = 1;
    tick();
    chk_st("R11 soft reset to idle", 0);
    chk(pipe_clr_o, "R11 clear pulse", pipe_clr_o, 1);
    soft_rst_i = 0;
    tick();
    chk(!pipe_clr_o, "R11 clear ends", pipe_clr_o, 0);
    chk_st("R2 restarts after soft reset", 1);
  endtask

  task automatic t_flag();
    go_idle();
    full_ien_i = 1;
    fifo_full_i = 1;
    tick();
    chk(full_flag_o, "R12 set on full edge", full_flag_o, 1);
    chk(full_irq_o, "R12 irq with enable", full_irq_o, 1);
    level_wr_i = 1;
    tick();
    level_wr_i = 0;
    chk(!full_flag_o, "R12 write clears", full_flag_o, 0);
    fifo_full_i = 0;
    tick();
    fifo_full_i = 1; level_wr_i = 1;
    tick();
    level_wr_i = 0;
    chk(full_flag_o, "R12 set wins over clear", full_flag_o, 1);
    full_ien_i = 0;
    tick();
    chk(full_flag_o && !full_irq_o, "R12 irq masked", {full_flag_o, full_irq_o}, 2);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_bypass();
    t_init_wait();
    t_one_test();
    t_swoff_restart();
    t_reload();
    t_force();
    t_error();
    t_flag();
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FIFO seq FAIL watchdog: actual %0d expected %0d", 1, 0);
    report();
  end
endmodule